// File: doc/BRIEF.md
# DMX512 Frame Transmitter Sequencer

This block sends one lighting-control frame on a single serial line each time it is asked to. A start request in the idle state latches the frame length and begins the sequence. The line is first held low as a break, then held high as a mark-after-break. The slots are then shifted out from a small external buffer at 250 kbaud. The buffer is read through a simple address and data port, and the data is taken in the same cycle the address is presented. Slot 0 is the start code and always goes out first.

The serial shifter is double-buffered, so consecutive slots leave back to back with no idle bit times between them. The sequencer holds `busy` until the final stop bit has physically left the line. For short frames it then pads with a high idle gap, so that two frame starts are never closer than 1300 us.

All intervals come from a one-shot microsecond timer. The timer is derived from the `CLK_HZ` parameter, as is the bit period.

Top module: `dmx_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx` is high and `busy` is low.
- R2: A `start` sampled high while idle sets `busy` from the next cycle. From that same cycle, `tx` is held low for 200 us (200·CLK_HZ/1e6 cycles).
- R3: After the break, `tx` is high for 200 us, plus two clock cycles spent loading the first slot.
- R4: Each slot is sent as one low start bit, eight data bits least significant first, and one high stop bit. Each bit lasts 4 us. Slot k is read from buffer address k, starting at address 0.
- R5: Slots follow each other with no idle bit time between one stop bit and the next start bit.
- R6: `busy` stays high until the stop bit of the last slot has fully completed, not merely until the last slot has been loaded.
- R7: If 400 + 40·L us is below 1300 us (L = latched length), the line stays high and `busy` stays high for the difference. As a result, `busy` lasts exactly 1300 us plus 3 cycles, and a start held high restarts after a single idle cycle.
- R8: If 400 + 40·L us is 1300 us or more, `busy` falls one cycle after the last stop bit ends.
- R9: A `start` sampled while `busy` is high has no effect on `tx` or on the frame timing.
- R10: `frame_len` (1 to 64) is captured at the accepted start. Changing it during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send a frame; honoured only when idle |
| frame_len | input | 7 | Number of slots including the start code, 1 to 64 |
| rd_addr | output | 6 | Slot buffer read address |
| rd_data | input | 8 | Slot buffer data for `rd_addr`, same cycle |
| busy | output | 1 | High while a frame or its padding is in progress |
| tx | output | 1 | Serial output line, high when idle |

## Verification
The hardest situation to reach from the ports is a request that is already pending in the one cycle the sequencer spends back in idle. This is what tests the minimum break-to-break spacing. The stimulus holds `start` high across a whole short frame. It checks for exactly one idle cycle and a second frame with identical timing. Lengths of 22 and 23 slots are driven on either side of the gap boundary (20 us of padding versus none). Separate frames inject start pulses and length changes mid-frame, while a reference model predicts every line level.

// File: rtl/dmx_frame_tx.sv
module dmx_frame_tx #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int BAUD      = 250_000,
  parameter int BREAK_US  = 200,
  parameter int MAB_US    = 200,
  parameter int SLOT_US   = 40,
  parameter int PERIOD_US = 1300,
  parameter int MAX_SLOTS = 64,
  localparam int AW = $clog2(MAX_SLOTS),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] frame_len,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          busy,
  output logic          tx
);

  localparam int TPU     = CLK_HZ / 1_000_000;
  localparam int BIT_CYC = CLK_HZ / BAUD;
  localparam int PW      = $clog2(TPU + 1);
  localparam int BW      = $clog2(BIT_CYC + 1);
  localparam int TW      = $clog2(PERIOD_US + 1);

  typedef enum logic [2:0] {S_IDLE, S_BREAK, S_MARK, S_DATA, S_LAST, S_GAP} state_t;

  state_t        state;
  logic [LW-1:0] len_q, pos;
  logic [PW-1:0] pre;
  logic [TW-1:0] tmr;
  logic [7:0]    hold;
  logic          hold_v;
  logic [9:0]    sh;
  logic          sh_busy;
  logic [BW-1:0] bt;
  logic [3:0]    bcnt;
  logic [31:0]   sent;

  wire tick     = (pre == PW'(TPU - 1));
  wire expire   = tick && (tmr == '0);
  wire bit_end  = sh_busy && (bt == BW'(BIT_CYC - 1));
  wire take     = hold_v && (!sh_busy || (bit_end && bcnt == 4'd9));
  wire fetch    = (state == S_DATA) && !hold_v && (pos < len_q);
  wire drained  = !hold_v && !sh_busy;
  wire need_gap = sent < 32'(PERIOD_US);

  assign sent    = 32'(BREAK_US + MAB_US) + 32'(SLOT_US) * 32'(len_q);
  assign busy    = (state != S_IDLE);
  assign rd_addr = pos[AW-1:0];
  assign tx      = (state == S_BREAK) ? 1'b0 : (sh_busy ? sh[0] : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      len_q <= '0;
      pre   <= '0;
      tmr   <= '0;
    end else begin
      pre <= tick ? '0 : pre + PW'(1);
      if (tick && tmr != '0) tmr <= tmr - TW'(1);
      case (state)
        S_IDLE: if (start) begin
          state <= S_BREAK;
          len_q <= frame_len;
          tmr   <= TW'(BREAK_US - 1);
          pre   <= '0;
        end
        S_BREAK: if (expire) begin
          state <= S_MARK;
          tmr   <= TW'(MAB_US - 1);
          pre   <= '0;
        end
        S_MARK: if (expire) state <= S_DATA;
        S_DATA: if (!hold_v && pos >= len_q) state <= S_LAST;
        S_LAST: if (drained) begin
          if (need_gap) begin
            state <= S_GAP;
            tmr   <= TW'(32'(PERIOD_US) - sent - 32'd1);
            pre   <= '0;
          end else begin
            state <= S_IDLE;
          end
        end
        S_GAP: if (expire) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      hold   <= '0;
      hold_v <= 1'b0;
    end else begin
      if (state == S_IDLE) pos <= '0;
      else if (fetch) pos <= pos + LW'(1);
      if (take) hold_v <= 1'b0;
      else if (fetch) begin
        hold   <= rd_data;
        hold_v <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '1;
      sh_busy <= 1'b0;
      bt      <= '0;
      bcnt    <= '0;
    end else if (take) begin
      sh      <= {1'b1, hold, 1'b0};
      sh_busy <= 1'b1;
      bt      <= '0;
      bcnt    <= '0;
    end else if (sh_busy) begin
      if (bit_end) begin
        bt <= '0;
        if (bcnt == 4'd9) sh_busy <= 1'b0;
        else begin
          sh   <= {1'b1, sh[9:1]};
          bcnt <= bcnt + 4'd1;
        end
      end else begin
        bt <= bt + BW'(1);
      end
    end
  end

  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> tx);
  // R2
  break_entry_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy && start) |=> (busy && !tx));
  // R3
  mark_high_chk: assert property (@(posedge clk) disable iff (!rst_n) (state == S_MARK) |-> tx);
  // R4
  addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) pos <= len_q);
  // R6
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n) (state == S_LAST && sh_busy) |=> busy);
  // R8
  gap_short_chk: assert property (@(posedge clk) disable iff (!rst_n) (state == S_GAP) |-> need_gap);
  // R10
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(len_q));

endmodule

// File: tb/test_dmx_frame_tx.sv
`timescale 1ns/1ps
module test_dmx_frame_tx;
  localparam int CLK_HZ = 4_000_000;
  localparam int T = CLK_HZ / 1_000_000;
  localparam int B = CLK_HZ / 250_000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [6:0] frame_len = 7'd1;
  logic [5:0] rd_addr;
  logic [7:0] rd_data;
  logic busy, tx;
  logic [7:0] mem [64];
  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_active = 0, m_t = 0, m_len = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  assign rd_data = mem[rd_addr];

  dmx_frame_tx #(.CLK_HZ(CLK_HZ)) i_dmx_frame_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .tx(tx));

  function automatic int gap_us(int len);
    int s = 400 + 40 * len;
    return (s < 1300) ? 1300 - s : 0;
  endfunction

  function automatic int total_cycles(int len);
    return 400 * T + 3 + 10 * B * len + gap_us(len) * T;
  endfunction

  function automatic int exp_tx(int t, int len);
    int k, slot, bitn;
    if (t < 200 * T) return 0;
    if (t < 400 * T + 2) return 1;
    k = t - (400 * T + 2);
    if (k >= 10 * B * len) return 1;
    slot = k / (10 * B);
    bitn = (k % (10 * B)) / B;
    if (bitn == 0) return 0;
    if (bitn == 9) return 1;
    return int'(mem[slot][bitn - 1]);
  endfunction

  function automatic string tag_of(int t, int len);
    int k;
    if (t < 200 * T) return "R2";
    if (t < 400 * T + 2) return "R3";
    k = t - (400 * T + 2);
    if (k < 10 * B) return "R4";
    if (k < 10 * B * len) return "R5";
    return (gap_us(len) > 0) ? "R7" : "R6";
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_active <= 0;
    else if (m_active == 0) begin
      if (start) begin
        m_active <= 1;
        m_t      <= 0;
        m_len    <= int'(frame_len);
      end
    end else if (m_t == total_cycles(m_len) - 1) m_active <= 0;
    else m_t <= m_t + 1;
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (m_active != 0) begin
        check(tag_of(m_t, m_len), int'(tx), exp_tx(m_t, m_len), "tx");
        check("R6", int'(busy), 1, "busy");
      end else begin
        check("R1", int'(tx), 1, "tx idle");
        check("R1", int'(busy), 0, "busy idle");
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run_frame(input int len, input bit disturb, input string tag);
    int c = 0;
    int tot = total_cycles(len);
    @(negedge clk);
    frame_len = 7'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) begin
      if (disturb && (c == 40 || c == tot / 2)) begin
        start = 1'b1;
        frame_len = 7'(len == 64 ? 1 : len + 7);
      end else start = 1'b0;
      c++;
      @(negedge clk);
    end
    start = 1'b0;
    check(tag, c, tot, "busy cycles");
  endtask

  initial begin
    int c1, c2, idle;
    for (int i = 0; i < 64; i++) mem[i] = 8'((i * 53 + 17) & 255);
    mem[0] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(tx), 1, "tx in reset");
    check("R1", int'(busy), 0, "busy in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7: padded frames; R4 and R5 checked per clock
    run_frame(1, 0, "R7");
    mem[1] = 8'hFF; mem[2] = 8'hFF; mem[3] = 8'h00; mem[4] = 8'h00;
    run_frame(5, 0, "R7");
    mem[1] = 8'hA5; mem[2] = 8'h5A; mem[3] = 8'h01; mem[4] = 8'h80;
    run_frame(22, 0, "R7");
    // R8: unpadded frames at and above the boundary
    run_frame(23, 0, "R8");
    run_frame(64, 0, "R8");
    // R10: length changed mid-frame
    run_frame(10, 1, "R10");
    // R9: starts while busy are ignored
    run_frame(30, 1, "R9");

    // R7: start held high, back-to-back frames
    @(negedge clk);
    frame_len = 7'd3;
    start = 1'b1;
    @(negedge clk);
    c1 = 0;
    while (busy) begin c1++; @(negedge clk); end
    idle = 0;
    while (!busy) begin idle++; @(negedge clk); end
    start = 1'b0;
    c2 = 0;
    while (busy) begin c2++; @(negedge clk); end
    check("R7", c1, total_cycles(3), "first busy cycles");
    check("R7", idle, 1, "idle cycles between frames");
    check("R7", c2, total_cycles(3), "second busy cycles");

    repeat (5) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule